// File: doc/BRIEF.md
# Release-on-access bus interrupter

This block raises a prioritized interrupt request toward the host bus from the status of an output buffer. Software programs a 3-bit request level, an 8-bit status/ID byte and a source-select bit through one 16-bit configuration word. When the selected buffer condition is true and the level is nonzero, the block pulls low the one request line that belongs to that level. The condition is either "buffer holds at least one word" or "buffer is above half full".

The request is not cleared by the acknowledge. It stays asserted until the host has read enough words from the buffer to remove the condition. Its release therefore follows register traffic on the buffer and not the acknowledge handshake. During an acknowledge cycle for the pending level, the block answers with the status/ID byte on the low data lines.

A synchronous clear input models an access to the board's reset location. It restores the power-on configuration. The bus arbitration chain and the open-drain line drivers are not part of this block.

Top module: `bus_irq_gen`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after reset, the configuration word reads `16'h0F00`, every bit of `irq_n` is 1, `ack_out` is 0 and `ack_data` is 0.
- R2: A write with `cfg_we` high loads the level from bits 15..13, the source select from bit 12 and the status/ID from bits 7..0. `cfg_rdata` shows these fields in the same positions from the next cycle on, and bits 11..8 always read 1.
- R3: When the programmed level is 0, every bit of `irq_n` is 1 in the following cycle, whatever the buffer status.
- R4: With source select 0, a request is driven in the cycle after `buf_half` is sampled high while the level is nonzero.
- R5: With source select 1, a request is driven in the cycle after `buf_empty` is sampled low while the level is nonzero.
- R6: A driven request pulls low only bit L-1 of `irq_n`, where L is the programmed level (1..7), and all other bits stay 1.
- R7: The request is removed in the cycle after the selected condition is sampled false. A condition that reads have cleared releases the line.
- R8: If `iack_valid` is high, `iack_level` equals the programmed level and that level's request is driven, then in the next cycle `ack_out` is 1 and `ack_data` carries the status/ID.
- R9: An acknowledge with a different level, or with no request driven for the programmed level, gives `ack_out` 0 and `ack_data` 0 in the next cycle.
- R10: `cfg_clr` sets the level to 0, the source select to 0 and the status/ID to 0 at the next edge. It takes priority over a write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_clr | input | 1 | Synchronous restore of the power-on configuration |
| cfg_we | input | 1 | Configuration word write strobe |
| cfg_wdata | input | 16 | Configuration word write data |
| cfg_rdata | output | 16 | Configuration word read-back |
| buf_empty | input | 1 | Buffer holds no word |
| buf_half | input | 1 | Buffer is above half full |
| iack_valid | input | 1 | Acknowledge cycle in progress |
| iack_level | input | 3 | Level being acknowledged |
| irq_n | output | 7 | Active-low request lines, bit L-1 for level L |
| ack_out | output | 1 | Acknowledge answered by this block |
| ack_data | output | 8 | Status/ID returned during the acknowledge |

## Verification
Two events can land on the same clock edge. One is an acknowledge cycle; the other is a configuration write or clear that changes the level the acknowledge is compared against. A second collision is a buffer read that drops the condition in the same cycle as an acknowledge for the still-driven line. The stimulus changes configuration, buffer status and acknowledge inputs independently on every cycle, so these collisions occur many times. A behavioural model compares the result on every cycle. In the model, the acknowledge is judged against the level and request that were in force before the edge, and the clear wins over a concurrent write.

// File: rtl/bus_irq_pkg.sv
package bus_irq_pkg;
  localparam int LVL_W   = 3;
  localparam int ID_W    = 8;
  localparam int WORD_W  = 16;
  localparam int NLINE   = (1 << LVL_W) - 1;
  localparam int LVL_LSB = WORD_W - LVL_W;
  localparam int SRC_BIT = LVL_LSB - 1;
  localparam int PAD_W   = SRC_BIT - ID_W;

  // one-hot request vector for a level; level 0 gives no line
  function automatic logic [NLINE-1:0] line_of(input logic [LVL_W-1:0] lvl);
    logic [NLINE-1:0] v;
    v = '0;
    for (int i = 1; i <= NLINE; i++)
      if (lvl == LVL_W'(i)) v[i-1] = 1'b1;
    return v;
  endfunction

  function automatic logic [WORD_W-1:0] pack_cfg(input logic [LVL_W-1:0] lvl,
                                                 input logic src,
                                                 input logic [ID_W-1:0] id);
    return {lvl, src, {PAD_W{1'b1}}, id};
  endfunction
endpackage

// File: rtl/irq_cfg_reg.sv
module irq_cfg_reg
  import bus_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              we,
  input  logic [WORD_W-1:0] wdata,
  output logic [LVL_W-1:0]  lvl_q,
  output logic              src_q,
  output logic [ID_W-1:0]   id_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= '0;
      src_q <= 1'b0;
      id_q  <= '0;
    end else if (clr) begin
      lvl_q <= '0;
      src_q <= 1'b0;
      id_q  <= '0;
    end else if (we) begin
      lvl_q <= wdata[WORD_W-1:LVL_LSB];
      src_q <= wdata[SRC_BIT];
      id_q  <= wdata[ID_W-1:0];
    end
  end
endmodule

// File: rtl/irq_cond_sel.sv
module irq_cond_sel (
  input  logic src,
  input  logic buf_empty,
  input  logic buf_half,
  output logic cond
);
  always_comb cond = src ? !buf_empty : buf_half;
endmodule

// File: rtl/irq_ack_unit.sv
module irq_ack_unit
  import bus_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             iack_valid,
  input  logic [LVL_W-1:0] iack_level,
  input  logic [LVL_W-1:0] lvl,
  input  logic [NLINE-1:0] line,
  input  logic [ID_W-1:0]  id,
  output logic             ack_out,
  output logic [ID_W-1:0]  ack_data
);
  logic pending;
  logic hit;
  always_comb begin
    pending = (|line) && (line == line_of(lvl));
    hit     = iack_valid && (iack_level == lvl) && pending;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_out  <= 1'b0;
      ack_data <= '0;
    end else begin
      ack_out  <= hit;
      ack_data <= hit ? id : '0;
    end
  end
endmodule

// File: rtl/bus_irq_gen.sv
module bus_irq_gen
  import bus_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_clr,
  input  logic              cfg_we,
  input  logic [WORD_W-1:0] cfg_wdata,
  output logic [WORD_W-1:0] cfg_rdata,
  input  logic              buf_empty,
  input  logic              buf_half,
  input  logic              iack_valid,
  input  logic [LVL_W-1:0]  iack_level,
  output logic [NLINE-1:0]  irq_n,
  output logic              ack_out,
  output logic [ID_W-1:0]   ack_data
);
  logic [LVL_W-1:0] lvl_q;
  logic             src_q;
  logic [ID_W-1:0]  id_q;
  logic             cond_w;
  logic [NLINE-1:0] line_q;

  irq_cfg_reg u_cfg (
    .clk(clk), .rst_n(rst_n), .clr(cfg_clr), .we(cfg_we), .wdata(cfg_wdata),
    .lvl_q(lvl_q), .src_q(src_q), .id_q(id_q)
  );

  irq_cond_sel u_cond (
    .src(src_q), .buf_empty(buf_empty), .buf_half(buf_half), .cond(cond_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) line_q <= '0;
    else        line_q <= cond_w ? line_of(lvl_q) : '0;
  end

  irq_ack_unit u_ack (
    .clk(clk), .rst_n(rst_n), .iack_valid(iack_valid), .iack_level(iack_level),
    .lvl(lvl_q), .line(line_q), .id(id_q), .ack_out(ack_out), .ack_data(ack_data)
  );

  always_comb begin
    irq_n     = ~line_q;
    cfg_rdata = pack_cfg(lvl_q, src_q, id_q);
  end
endmodule

// File: rtl/bus_irq_chk.sv
module bus_irq_chk
  import bus_irq_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_clr,
  input logic             iack_valid,
  input logic [NLINE-1:0] irq_n,
  input logic             ack_out,
  input logic             cond_w,
  input logic [LVL_W-1:0] lvl_q,
  input logic             src_q
);
  assert_one_line_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~irq_n));
  assert_level0_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_q == '0) |=> (&irq_n));
  assert_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !cond_w |=> (&irq_n));
  assert_ack_needs_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ack_out |-> $past(iack_valid));
  assert_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_clr |=> (lvl_q == '0 && !src_q));
endmodule

bind bus_irq_gen bus_irq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_clr(cfg_clr), .iack_valid(iack_valid),
  .irq_n(irq_n), .ack_out(ack_out), .cond_w(cond_w), .lvl_q(lvl_q), .src_q(src_q)
);

// File: tb/tb_bus_irq_gen.sv
module tb_bus_irq_gen;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_clr = 1'b0, cfg_we = 1'b0;
  logic [15:0] cfg_wdata = '0;
  logic [15:0] cfg_rdata;
  logic        buf_empty = 1'b1, buf_half = 1'b0;
  logic        iack_valid = 1'b0;
  logic [2:0]  iack_level = '0;
  logic [6:0]  irq_n;
  logic        ack_out;
  logic [7:0]  ack_data;

  int n_cmp = 0, n_bad = 0;
  int m_lvl = 0, m_src = 0, m_id = 0, m_line = 0, m_ack = 0, m_ackd = 0;
  string t_irq = "R1", t_cfg = "R1", t_ack = "R1";
  int hits = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_irq_gen dut (
    .clk(clk), .rst_n(rst_n), .cfg_clr(cfg_clr), .cfg_we(cfg_we),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .buf_empty(buf_empty),
    .buf_half(buf_half), .iack_valid(iack_valid), .iack_level(iack_level),
    .irq_n(irq_n), .ack_out(ack_out), .ack_data(ack_data)
  );

  // behavioural reference, updated at each rising edge from pre-edge state
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_lvl = 0; m_src = 0; m_id = 0; m_line = 0; m_ack = 0; m_ackd = 0;
      t_irq = "R1"; t_cfg = "R1"; t_ack = "R1";
    end else begin
      bit cond, hit;
      int nl;
      cond = (m_src != 0) ? !buf_empty : buf_half;
      nl   = (m_lvl != 0 && cond) ? m_lvl : 0;
      hit  = iack_valid && (int'(iack_level) == m_lvl) && (m_line == m_lvl) && (m_line != 0);
      if (m_line != 0 && nl == 0 && !cond) t_irq = "R7";
      else if (m_lvl == 0)                 t_irq = "R3";
      else if (nl != 0)                    t_irq = (m_src != 0) ? "R5" : "R4";
      else                                 t_irq = "R6";
      t_ack  = hit ? "R8" : "R9";
      if (hit) hits++;
      m_ack  = hit ? 1 : 0;
      m_ackd = hit ? m_id : 0;
      m_line = nl;
      if (cfg_clr) begin
        m_lvl = 0; m_src = 0; m_id = 0; t_cfg = "R10";
      end else if (cfg_we) begin
        m_lvl = int'(cfg_wdata[15:13]); m_src = int'(cfg_wdata[12]);
        m_id = int'(cfg_wdata[7:0]); t_cfg = "R2";
      end
    end
  end

  task automatic check(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    int exp_irq, exp_cfg;
    exp_irq = 7'h7F;
    if (m_line != 0) exp_irq = exp_irq & ~(1 << (m_line - 1));
    exp_cfg = (m_lvl << 13) | (m_src << 12) | 16'h0F00 | m_id;
    check({t_irq, " irq_n"}, int'(irq_n), exp_irq);
    check({t_cfg, " cfg_rdata"}, int'(cfg_rdata), exp_cfg);
    check({t_ack, " ack_out"}, int'(ack_out), m_ack);
    check({t_ack, " ack_data"}, int'(ack_data), m_ackd);
  endtask

  task automatic cycle();
    @(negedge clk);
    compare_all();
  endtask

  task automatic drive_idle();
    cfg_clr = 0; cfg_we = 0; iack_valid = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) cycle();
    rst_n = 1'b1;
    cycle();
    // R2/R5/R6/R8: directed level 5, not-empty source, id A5
    cfg_we = 1; cfg_wdata = {3'd5, 1'b1, 4'h0, 8'hA5};
    cycle(); drive_idle();
    buf_empty = 0;
    cycle(); cycle();
    iack_valid = 1; iack_level = 3'd5;
    cycle();
    iack_valid = 1; iack_level = 3'd4;  // R9: wrong level
    cycle(); drive_idle();
    buf_empty = 1;                      // R7: reads drained the buffer
    cycle(); cycle();
    // R4: half-full source, level 2
    cfg_we = 1; cfg_wdata = {3'd2, 1'b0, 4'h0, 8'h3C};
    cycle(); drive_idle();
    buf_empty = 0; buf_half = 1;
    cycle(); cycle();
    buf_half = 0; iack_valid = 1; iack_level = 3'd2; // ack against driven line
    cycle(); drive_idle();
    cycle();
    // R10: clear with concurrent write
    cfg_clr = 1; cfg_we = 1; cfg_wdata = 16'hFFFF;
    cycle(); drive_idle();
    cycle();
    // random mixed traffic, collisions of ack with write/clear/condition changes
    for (int i = 0; i < 4000; i++) begin
      cfg_we     = ($urandom_range(0, 7) == 0);
      cfg_clr    = ($urandom_range(0, 63) == 0);
      cfg_wdata  = 16'($urandom);
      if ($urandom_range(0, 5) == 0) buf_empty = ~buf_empty;
      if ($urandom_range(0, 5) == 0) buf_half  = ~buf_half;
      iack_valid = ($urandom_range(0, 2) == 0);
      iack_level = ($urandom_range(0, 1) == 0) ? 3'(m_lvl) : 3'($urandom);
      cycle();
    end
    drive_idle();
    cycle();
    n_cmp++;
    if (hits < 10) begin
      n_bad++;
      $display("FAIL R8 coverage: actual %0d expected at least 10", hits);
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule